// File: doc/BRIEF.md
# Semaphore-Counted Descriptor Channel Controller

This block sequences work for a memory-to-memory cipher and hash co-processor. Up to four channels each hold a command pointer, a pending-work counter and an error status word. Software points a channel at an eight-word descriptor in memory and then adds to its counter. An enabled channel that has pending work and no error is then eligible to run. A single fetch unit serves the channels one at a time. It reads the descriptor over a word-read port and hands the decoded fields to a datapath through a start/done handshake. In this block the datapath is a fixed-latency stub.

When a descriptor finishes, it may decrement the counter and may raise the channel's interrupt flag. If work remains, the channel follows the descriptor's next-command address. Errors set per-channel status bits and halt the channel until software clears them. Both the interrupt flags and the error bits are cleared by writing ones.

Descriptor word order, counted from the descriptor address in steps of 4 bytes:
- word 0: next-command address
- word 1: control word 0
- word 2: control word 1
- word 3: source
- word 4: destination
- word 5: length
- word 6: payload
- word 7: status (fetched and ignored)

Top module: `dcx_ctrl`

## Requirements
- R1: After reset, every readable register reads zero and `irq` is low. The readable registers are:
  - 0x010: interrupt flags
  - 0x020: channel enables
  - 0x100 + n*0x40 + 0x00: command pointer of channel n
  - 0x100 + n*0x40 + 0x10: pending count of channel n
  - 0x100 + n*0x40 + 0x20: error status of channel n
- R2: A write to a channel's count register (+0x10) adds the written value to the count. Any value above 255 counts as 255. The count saturates at 255 and never wraps below zero.
- R3: A channel whose bit in the enable register (0x020, bit n) is 0 never starts a descriptor, whatever its count.
- R4: A started channel reads the eight descriptor words at pointer+0, +4, ... +28, in that order. It then pulses `dp_start` with the fields on the `dp_*` outputs:
  - control word 0 appears unchanged on `dp_ctrl0`.
  - `dp_sel[0]` is control word 0 bit 5 (cipher path).
  - `dp_sel[1]` is control word 0 bit 6 (hash path).
- R5: On completion without fault:
  - If control word 0 bit 1 is set, the channel's count drops by one.
  - If control word 0 bit 0 is set, interrupt flag bit n (register 0x010) is set. `irq` is the OR of all flags.
- R6: Writing ones to 0x018 clears the matching interrupt flags; flags written with zero stay. Writing ones to a channel's +0x28 register clears the matching error status bits.
- R7: A nonzero next-command address is loaded into the command pointer on completion. If the count is still nonzero, the channel runs the descriptor found there next.
- R8: A completion that leaves the count nonzero with a next-command address of zero sets error bit 1 and halts the channel.
- R9: When several channels are eligible at once, the lowest-numbered one is started first. Only one descriptor is in flight at any time.
- R10: A command pointer that is not word aligned (bits [1:0] nonzero) has these effects:
  - error bit 0 is set and interrupt flag n is raised;
  - no memory read is issued and no datapath start occurs;
  - the count is left unchanged.
- R11: A nonzero `eng_fault` at datapath completion has these effects:
  - error bit 3 is set and interrupt flag n is raised;
  - the count is not decremented.
- R12: A channel with any error bit set does not start. After software clears its error bits, it resumes with its remaining count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| mem_req | output | 1 | Descriptor word read request, held until `mem_rvalid` |
| mem_addr | output | AW (32) | Byte address of the requested word |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| eng_fault | input | FAULT_W (4) | Error code from the engine, sampled at completion |
| dp_start | output | 1 | One-cycle datapath start |
| dp_chan | output | CW (2) | Channel owning the descriptor |
| dp_sel | output | 2 | Hash and cipher path selects |
| dp_ctrl0 | output | 32 | Control word 0 |
| dp_ctrl1 | output | 32 | Control word 1 |
| dp_src | output | 32 | Source address |
| dp_dst | output | 32 | Destination address |
| dp_len | output | 32 | Transfer length |
| dp_payload | output | 32 | Payload address |
| dp_done | output | 1 | Datapath completion pulse |
| irq | output | 1 | OR of the interrupt flags |

## Verification
The bench uses the default parameters:
- four channels, so channel 0 and channel 2 can compete for the arbiter while channel 1 stays disabled with a nonzero count;
- an 8-bit count, so random and directed additions reach the 255 ceiling within a handful of writes;
- a three-cycle stub latency, so each descriptor retires in a few dozen cycles and chains, halts and resumes all fit in a short run.

A 4-bit fault input lets a nonzero engine error be injected on a chosen descriptor.

// File: rtl/dcx_pkg.sv
package dcx_pkg;
   localparam int DESC_WORDS = 8;
   // descriptor word positions
   localparam int DW_NEXT = 0;
   localparam int DW_CTL0 = 1;
   localparam int DW_CTL1 = 2;
   localparam int DW_SRC  = 3;
   localparam int DW_DST  = 4;
   localparam int DW_LEN  = 5;
   localparam int DW_PAY  = 6;
   // control word 0 bits decoded here
   localparam int C0_IRQ    = 0;
   localparam int C0_DECR   = 1;
   localparam int C0_CIPHER = 5;
   localparam int C0_HASH   = 6;
   // channel error bits
   localparam int ERR_ALIGN  = 0;
   localparam int ERR_NULL   = 1;
   localparam int ERR_UNDER  = 2;
   localparam int ERR_ENGINE = 3;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_FETCH,
      ST_RUN,
      ST_WAIT
   } dcx_state_e;
endpackage

// File: rtl/dcx_prio_arb.sv
module dcx_prio_arb #(
   parameter int N  = 4,
   parameter int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic [IW-1:0] idx,
   output logic          any
);
   if (N == 1) begin : g_single
      assign idx = '0;
      assign any = req[0];
   end else begin : g_multi
      always_comb begin
         idx = '0;
         any = 1'b0;
         for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
               idx = IW'(i);
               any = 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/dcx_chan_slot.sv
module dcx_chan_slot
   import dcx_pkg::*;
#(
   parameter int AW    = 32,
   parameter int CNT_W = 8,
   parameter int ERR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             sw_ptr_we,
   input  logic             sw_sema_we,
   input  logic             sw_clr_we,
   input  logic [31:0]      sw_wdata,
   input  logic             hw_ptr_we,
   input  logic [AW-1:0]    hw_ptr,
   input  logic             hw_dec,
   input  logic [ERR_W-1:0] hw_err,
   output logic [AW-1:0]    ptr_q,
   output logic [CNT_W-1:0] cnt_q,
   output logic [ERR_W-1:0] err_q,
   output logic             ready
);
   localparam logic [CNT_W-1:0] CMAX = '1;

   logic [CNT_W-1:0] add_v, cnt_d;
   logic [CNT_W:0]   sum;
   logic             dec_ok, under;
   logic [ERR_W-1:0] under_v, clr_v, err_d;
   logic [AW-1:0]    ptr_d;

   always_comb begin
      add_v   = (|sw_wdata[31:CNT_W]) ? CMAX : sw_wdata[CNT_W-1:0];
      dec_ok  = hw_dec && (cnt_q != '0);
      under   = hw_dec && (cnt_q == '0);
      sum     = {1'b0, cnt_q} + (sw_sema_we ? {1'b0, add_v} : '0)
              - {{CNT_W{1'b0}}, dec_ok};
      cnt_d   = (sum > {1'b0, CMAX}) ? CMAX : sum[CNT_W-1:0];
      under_v = '0;
      under_v[ERR_UNDER] = under;
      clr_v   = sw_clr_we ? sw_wdata[ERR_W-1:0] : '0;
      err_d   = (err_q & ~clr_v) | hw_err | under_v;
      ptr_d   = hw_ptr_we ? hw_ptr : (sw_ptr_we ? sw_wdata[AW-1:0] : ptr_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
         cnt_q <= '0;
         err_q <= '0;
      end else begin
         ptr_q <= ptr_d;
         cnt_q <= cnt_d;
         err_q <= err_d;
      end
   end

   assign ready = en && (cnt_q != '0) && (err_q == '0);
endmodule

// File: rtl/dcx_stub_eng.sv
module dcx_stub_eng #(
   parameter int LAT = 3,
   parameter int FW  = 4,
   parameter int LW  = $clog2(LAT + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [FW-1:0] fault_in,
   output logic          busy,
   output logic          done,
   output logic [FW-1:0] err
);
   logic [LW-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         left_q <= '0;
      end else if (start) begin
         busy   <= 1'b1;
         left_q <= LW'(LAT - 1);
      end else if (done) begin
         busy   <= 1'b0;
      end else if (busy) begin
         left_q <= left_q - 1'b1;
      end
   end

   assign done = busy && (left_q == '0);
   assign err  = done ? fault_in : '0;
endmodule

// File: rtl/dcx_ctrl.sv
module dcx_ctrl
   import dcx_pkg::*;
#(
   parameter int NCH      = 4,
   parameter int AW       = 32,
   parameter int CNT_W    = 8,
   parameter int ERR_W    = 8,
   parameter int FAULT_W  = 4,
   parameter int STUB_LAT = 3,
   parameter int CW       = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_we,
   input  logic [11:0]        reg_addr,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   output logic               mem_req,
   output logic [AW-1:0]      mem_addr,
   input  logic               mem_rvalid,
   input  logic [31:0]        mem_rdata,
   input  logic [FAULT_W-1:0] eng_fault,
   output logic               dp_start,
   output logic [CW-1:0]      dp_chan,
   output logic [1:0]         dp_sel,
   output logic [31:0]        dp_ctrl0,
   output logic [31:0]        dp_ctrl1,
   output logic [31:0]        dp_src,
   output logic [31:0]        dp_dst,
   output logic [31:0]        dp_len,
   output logic [31:0]        dp_payload,
   output logic               dp_done,
   output logic               irq
);
   localparam int WIW = $clog2(DESC_WORDS);

   if (NCH < 1 || NCH > 4) begin : g_bad_nch
      $error("dcx_ctrl: NCH must be 1..4");
   end
   if (AW < 12 || AW > 32) begin : g_bad_aw
      $error("dcx_ctrl: AW must be 12..32");
   end
   if (CNT_W < 2 || CNT_W > 16) begin : g_bad_cnt
      $error("dcx_ctrl: CNT_W must be 2..16");
   end
   if (ERR_W < 4 || ERR_W > 32) begin : g_bad_err
      $error("dcx_ctrl: ERR_W must be 4..32");
   end
   if (STUB_LAT < 1) begin : g_bad_lat
      $error("dcx_ctrl: STUB_LAT must be at least 1");
   end

   // register decode
   logic       g_sel, c_sel, g_clr_we, g_en_we;
   logic [1:0] c_idx;
   logic [5:0] c_off;
   assign g_sel    = (reg_addr[11:8] == 4'h0);
   assign c_sel    = (reg_addr[11:8] == 4'h1);
   assign c_idx    = reg_addr[7:6];
   assign c_off    = reg_addr[5:0];
   assign g_clr_we = reg_we && g_sel && (reg_addr[7:0] == 8'h18);
   assign g_en_we  = reg_we && g_sel && (reg_addr[7:0] == 8'h20);

   dcx_state_e         st;
   logic [WIW-1:0]     widx;
   logic [CW-1:0]      cur;
   logic [AW-1:0]      base;
   logic [NCH-1:0]     en_q, flags_q, flag_set;
   logic [31:0]        desc [DESC_WORDS];

   logic [AW-1:0]      ch_ptr [NCH];
   logic [ERR_W-1:0]   ch_err [NCH];
   logic [NCH*CNT_W-1:0] cnt_flat;
   logic [NCH-1:0]     ready;

   logic [CW-1:0]      arb_idx;
   logic               arb_any;
   logic               eng_busy, eng_done;
   logic [FAULT_W-1:0] eng_err;

   dcx_prio_arb #(.N(NCH), .IW(CW)) u_arb (
      .req(ready), .idx(arb_idx), .any(arb_any)
   );

   // launch and retire decisions
   logic [AW-1:0]    sel_ptr;
   logic [CNT_W-1:0] cur_cnt;
   logic             launch, misal, retire, fault, rt_dec, rt_ptr_we, rt_flag;
   logic             remain_nz;
   logic [ERR_W-1:0] rt_err, al_err;
   logic [AW-1:0]    nxt;

   always_comb begin
      sel_ptr = '0;
      cur_cnt = '0;
      for (int n = 0; n < NCH; n++) begin
         if (arb_idx == CW'(n)) sel_ptr = ch_ptr[n];
         if (cur == CW'(n))     cur_cnt = cnt_flat[n*CNT_W +: CNT_W];
      end
      launch    = (st == ST_IDLE) && arb_any;
      misal     = launch && (sel_ptr[1:0] != 2'b00);
      retire    = (st == ST_WAIT) && eng_done;
      fault     = retire && (eng_err != '0);
      nxt       = desc[DW_NEXT][AW-1:0];
      rt_dec    = retire && !fault && desc[DW_CTL0][C0_DECR];
      remain_nz = rt_dec ? (cur_cnt > CNT_W'(1)) : (cur_cnt != '0);
      rt_ptr_we = retire && !fault && (nxt != '0);
      rt_flag   = retire && (fault || desc[DW_CTL0][C0_IRQ]);
      rt_err    = '0;
      if (fault)
         rt_err[ERR_ENGINE] = 1'b1;
      else if (retire && remain_nz && nxt == '0)
         rt_err[ERR_NULL] = 1'b1;
      al_err = '0;
      al_err[ERR_ALIGN] = misal;
   end

   for (genvar n = 0; n < NCH; n++) begin : g_ch
      logic hit, is_cur, is_gnt;
      assign hit    = reg_we && c_sel && (c_idx == 2'(n));
      assign is_cur = (cur == CW'(n));
      assign is_gnt = (arb_idx == CW'(n));
      assign flag_set[n] = (rt_flag && is_cur) || (misal && is_gnt);

      dcx_chan_slot #(.AW(AW), .CNT_W(CNT_W), .ERR_W(ERR_W)) u_slot (
         .clk        (clk),
         .rst_n      (rst_n),
         .en         (en_q[n]),
         .sw_ptr_we  (hit && c_off == 6'h00),
         .sw_sema_we (hit && c_off == 6'h10),
         .sw_clr_we  (hit && c_off == 6'h28),
         .sw_wdata   (reg_wdata),
         .hw_ptr_we  (rt_ptr_we && is_cur),
         .hw_ptr     (nxt),
         .hw_dec     (rt_dec && is_cur),
         .hw_err     ((is_cur ? rt_err : '0) | (is_gnt ? al_err : '0)),
         .ptr_q      (ch_ptr[n]),
         .cnt_q      (cnt_flat[n*CNT_W +: CNT_W]),
         .err_q      (ch_err[n]),
         .ready      (ready[n])
      );
   end

   dcx_stub_eng #(.LAT(STUB_LAT), .FW(FAULT_W)) u_eng (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (dp_start),
      .fault_in (eng_fault),
      .busy     (eng_busy),
      .done     (eng_done),
      .err      (eng_err)
   );

   // sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         widx    <= '0;
         cur     <= '0;
         base    <= '0;
         en_q    <= '0;
         flags_q <= '0;
         for (int i = 0; i < DESC_WORDS; i++) desc[i] <= '0;
      end else begin
         if (g_en_we) en_q <= reg_wdata[NCH-1:0];
         flags_q <= (flags_q & ~(g_clr_we ? reg_wdata[NCH-1:0] : '0)) | flag_set;
         unique case (st)
            ST_IDLE: begin
               if (arb_any) begin
                  cur  <= arb_idx;
                  base <= sel_ptr;
                  widx <= '0;
                  if (!misal) st <= ST_FETCH;
               end
            end
            ST_FETCH: begin
               if (mem_rvalid) begin
                  desc[widx] <= mem_rdata;
                  widx       <= widx + 1'b1;
                  if (widx == WIW'(DESC_WORDS - 1)) st <= ST_RUN;
               end
            end
            ST_RUN:  st <= ST_WAIT;
            ST_WAIT: if (eng_done) st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign mem_req    = (st == ST_FETCH);
   assign mem_addr   = base + AW'({widx, 2'b00});
   assign dp_start   = (st == ST_RUN);
   assign dp_chan    = cur;
   assign dp_sel     = {desc[DW_CTL0][C0_HASH], desc[DW_CTL0][C0_CIPHER]};
   assign dp_ctrl0   = desc[DW_CTL0];
   assign dp_ctrl1   = desc[DW_CTL1];
   assign dp_src     = desc[DW_SRC];
   assign dp_dst     = desc[DW_DST];
   assign dp_len     = desc[DW_LEN];
   assign dp_payload = desc[DW_PAY];
   assign dp_done    = eng_done;
   assign irq        = |flags_q;

   // register read
   always_comb begin
      reg_rdata = '0;
      if (g_sel) begin
         if (reg_addr[7:0] == 8'h10) reg_rdata = 32'(flags_q);
         if (reg_addr[7:0] == 8'h20) reg_rdata = 32'(en_q);
      end else if (c_sel) begin
         for (int n = 0; n < NCH; n++) begin
            if (c_idx == 2'(n)) begin
               if (c_off == 6'h00) reg_rdata = 32'(ch_ptr[n]);
               if (c_off == 6'h10) reg_rdata = 32'(cnt_flat[n*CNT_W +: CNT_W]);
               if (c_off == 6'h20) reg_rdata = 32'(ch_err[n]);
            end
         end
      end
   end
endmodule

// File: rtl/dcx_ctrl_chk.sv
module dcx_ctrl_chk #(
   parameter int NCH   = 4,
   parameter int AW    = 32,
   parameter int CNT_W = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 mem_req,
   input logic                 mem_rvalid,
   input logic [AW-1:0]        mem_addr,
   input logic                 dp_start,
   input logic                 eng_busy,
   input logic [NCH*CNT_W-1:0] cnt_flat
);
   localparam logic [CNT_W-1:0] CMAX = '1;

   // R4
   fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

   // R10
   fetch_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[1:0] == 2'b00));

   // R9
   single_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dp_start |-> !eng_busy);

   // R9
   start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dp_start |=> !dp_start);

   for (genvar n = 0; n < NCH; n++) begin : g_cnt
      // R2
      count_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (cnt_flat[n*CNT_W +: CNT_W] == CMAX) |=>
         (cnt_flat[n*CNT_W +: CNT_W] >= CMAX - 1'b1));
   end
endmodule

bind dcx_ctrl dcx_ctrl_chk #(.NCH(NCH), .AW(AW), .CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mem_req    (mem_req),
   .mem_rvalid (mem_rvalid),
   .mem_addr   (mem_addr),
   .dp_start   (dp_start),
   .eng_busy   (eng_busy),
   .cnt_flat   (cnt_flat)
);

// File: tb/dcx_ctrl_test.sv
module dcx_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic [3:0]  eng_fault = '0;
   logic        dp_start, dp_done, irq;
   logic [1:0]  dp_chan, dp_sel;
   logic [31:0] dp_ctrl0, dp_ctrl1, dp_src, dp_dst, dp_len, dp_payload;

   int checks = 0;
   int fails  = 0;

   dcx_ctrl uut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
      .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .eng_fault(eng_fault), .dp_start(dp_start), .dp_chan(dp_chan),
      .dp_sel(dp_sel), .dp_ctrl0(dp_ctrl0), .dp_ctrl1(dp_ctrl1),
      .dp_src(dp_src), .dp_dst(dp_dst), .dp_len(dp_len),
      .dp_payload(dp_payload), .dp_done(dp_done), .irq(irq)
   );

   always #4 clk = ~clk;

   // word memory answering one cycle after each request
   logic [31:0] mem [0:255];
   always @(posedge clk) begin
      mem_rvalid <= mem_req && !mem_rvalid;
      mem_rdata  <= mem[mem_addr[9:2]];
   end

   // datapath start monitor
   int          n_starts = 0;
   int          ch1_starts = 0;
   int          start_chan [0:31];
   logic [31:0] s_c0, s_c1, s_src, s_dst, s_len, s_pay;
   logic [1:0]  s_sel;
   always @(negedge clk) begin
      if (dp_start) begin
         if (n_starts < 32) start_chan[n_starts] = int'(dp_chan);
         if (dp_chan == 2'd1) ch1_starts++;
         s_c0 = dp_ctrl0; s_c1 = dp_ctrl1; s_src = dp_src;
         s_dst = dp_dst; s_len = dp_len; s_pay = dp_payload; s_sel = dp_sel;
         n_starts++;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [11:0] cadr(input int ch, input int off);
      return 12'(32'h100 + ch * 32'h40 + off);
   endfunction

   function automatic int sat_add(input int cur, input logic [31:0] v);
      int a = (v > 32'd255) ? 255 : int'(v);
      return (cur + a > 255) ? 255 : cur + a;
   endfunction

   task automatic put_desc(input int a, input logic [31:0] nx, input logic [31:0] c0,
                           input logic [31:0] c1, input logic [31:0] src,
                           input logic [31:0] dst, input logic [31:0] len,
                           input logic [31:0] pay);
      mem[a/4 + 0] = nx;  mem[a/4 + 1] = c0;  mem[a/4 + 2] = c1;
      mem[a/4 + 3] = src; mem[a/4 + 4] = dst; mem[a/4 + 5] = len;
      mem[a/4 + 6] = pay; mem[a/4 + 7] = 32'hDEAD_0000;
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] r;
      int          base_starts, exp_cnt;
      for (int i = 0; i < 256; i++) mem[i] = '0;
      put_desc(32'h40,  32'h0,   32'h923, 32'h10, 32'h1000, 32'h2000, 32'd64, 32'h3000);
      put_desc(32'h80,  32'hC0,  32'h1042, 32'h2, 32'h1100, 32'h2100, 32'd16, 32'h0);
      put_desc(32'hC0,  32'h100, 32'h43,  32'h2,  32'h1200, 32'h2200, 32'd32, 32'h0);
      put_desc(32'h100, 32'h0,   32'h3,   32'h0,  32'h1300, 32'h2300, 32'd48, 32'h0);
      put_desc(32'h140, 32'h0,   32'h3,   32'h0,  32'h5555, 32'h2400, 32'd80, 32'h0);
      void'($urandom(32'd77));
      idle(3);
      rst_n = 1'b1;
      idle(2);

      // R1 reset state
      rd(12'h010, r); check("R1 flags", r, 0);
      rd(12'h020, r); check("R1 enables", r, 0);
      rd(cadr(0, 'h00), r); check("R1 ptr", r, 0);
      rd(cadr(0, 'h10), r); check("R1 count", r, 0);
      rd(cadr(0, 'h20), r); check("R1 status", r, 0);
      check("R1 irq", 32'(irq), 0);

      // R2 random additions on disabled channel 1, then the ceiling
      exp_cnt = 0;
      wr(cadr(1, 'h00), 32'h40);
      for (int i = 0; i < 5; i++) begin
         logic [31:0] v = 32'($urandom_range(0, 60));
         wr(cadr(1, 'h10), v);
         exp_cnt = sat_add(exp_cnt, v);
         rd(cadr(1, 'h10), r); check("R2 count add", r, 32'(exp_cnt));
      end
      wr(cadr(1, 'h10), 32'hFFFF_FFFF);
      exp_cnt = sat_add(exp_cnt, 32'hFFFF_FFFF);
      rd(cadr(1, 'h10), r); check("R2 saturate", r, 32'(exp_cnt));
      wr(cadr(1, 'h10), 32'd3);
      rd(cadr(1, 'h10), r); check("R2 hold at ceiling", r, 32'd255);
      idle(40);
      check("R3 disabled never starts", 32'(n_starts), 0);

      // R4 R5 single descriptor on channel 0
      wr(12'h020, 32'h1);
      wr(cadr(0, 'h00), 32'h40);
      wr(cadr(0, 'h10), 32'd1);
      idle(120);
      check("R4 one start", 32'(n_starts), 1);
      check("R4 chan", 32'(start_chan[0]), 0);
      check("R4 ctrl0 unchanged", s_c0, 32'h923);
      check("R4 path select", 32'(s_sel), 32'h1);
      check("R4 ctrl1", s_c1, 32'h10);
      check("R4 src", s_src, 32'h1000);
      check("R4 dst", s_dst, 32'h2000);
      check("R4 len", s_len, 32'd64);
      check("R4 payload", s_pay, 32'h3000);
      rd(cadr(0, 'h10), r); check("R5 decrement", r, 0);
      rd(12'h010, r); check("R5 flag", r, 32'h1);
      check("R5 irq", 32'(irq), 1);
      rd(cadr(0, 'h20), r); check("R5 no error", r, 0);

      // R6 write-one-to-clear of flags
      wr(12'h018, 32'h2);
      rd(12'h010, r); check("R6 unrelated bit keeps flag", r, 32'h1);
      wr(12'h018, 32'h1);
      rd(12'h010, r); check("R6 flag cleared", r, 0);
      check("R6 irq low", 32'(irq), 0);

      // R7 chaining A -> B
      base_starts = n_starts;
      wr(cadr(0, 'h00), 32'h80);
      wr(cadr(0, 'h10), 32'd2);
      idle(200);
      check("R7 two starts", 32'(n_starts - base_starts), 2);
      check("R7 second src", s_src, 32'h1200);
      check("R7 second ctrl0", s_c0, 32'h43);
      check("R4 hash select", 32'(s_sel), 32'h2);
      rd(cadr(0, 'h00), r); check("R7 ptr follows next", r, 32'h100);
      rd(cadr(0, 'h10), r); check("R7 count", r, 0);
      rd(12'h010, r); check("R5 flag from second", r, 32'h1);
      wr(12'h018, 32'hF);

      // R8 null next with work left, R12 resume after clear
      base_starts = n_starts;
      wr(cadr(0, 'h10), 32'd2);
      idle(150);
      check("R8 one start", 32'(n_starts - base_starts), 1);
      rd(cadr(0, 'h20), r); check("R8 null error", r, 32'h2);
      rd(cadr(0, 'h10), r); check("R8 count left", r, 32'd1);
      idle(100);
      check("R12 halted", 32'(n_starts - base_starts), 1);
      wr(cadr(0, 'h28), 32'hFF);
      idle(120);
      check("R12 resumed", 32'(n_starts - base_starts), 2);
      rd(cadr(0, 'h20), r); check("R6 status cleared", r, 0);
      rd(cadr(0, 'h10), r); check("R12 count drained", r, 0);
      wr(12'h018, 32'hF);

      // R10 misaligned pointer
      base_starts = n_starts;
      wr(cadr(0, 'h00), 32'h102);
      wr(cadr(0, 'h10), 32'd1);
      idle(60);
      check("R10 no start", 32'(n_starts - base_starts), 0);
      rd(cadr(0, 'h20), r); check("R10 align error", r, 32'h1);
      rd(12'h010, r); check("R10 flag", r, 32'h1);
      rd(cadr(0, 'h10), r); check("R10 count kept", r, 32'd1);
      wr(cadr(0, 'h00), 32'h100);
      wr(cadr(0, 'h28), 32'h1);
      idle(120);
      check("R12 runs after clear", 32'(n_starts - base_starts), 1);
      rd(cadr(0, 'h10), r); check("R12 count", r, 0);
      wr(12'h018, 32'hF);

      // R11 engine fault
      base_starts = n_starts;
      eng_fault = 4'h5;
      wr(cadr(0, 'h10), 32'd1);
      idle(120);
      check("R11 started", 32'(n_starts - base_starts), 1);
      rd(cadr(0, 'h20), r); check("R11 engine error", r, 32'h8);
      rd(cadr(0, 'h10), r); check("R11 no decrement", r, 32'd1);
      rd(12'h010, r); check("R11 flag", r, 32'h1);
      eng_fault = 4'h0;
      wr(cadr(0, 'h28), 32'h8);
      idle(120);
      rd(cadr(0, 'h10), r); check("R11 retry drains", r, 0);
      wr(12'h018, 32'hF);

      // R9 fixed priority between channels 0 and 2
      wr(12'h020, 32'h0);
      base_starts = n_starts;
      wr(cadr(0, 'h00), 32'h100);
      wr(cadr(0, 'h10), 32'd1);
      wr(cadr(2, 'h00), 32'h140);
      wr(cadr(2, 'h10), 32'd1);
      idle(20);
      check("R3 none while disabled", 32'(n_starts - base_starts), 0);
      wr(12'h020, 32'h5);
      idle(200);
      check("R9 two starts", 32'(n_starts - base_starts), 2);
      check("R9 first is ch0", 32'(start_chan[base_starts]), 0);
      check("R9 second is ch2", 32'(start_chan[base_starts + 1]), 2);
      check("R9 ch2 src", s_src, 32'h5555);
      rd(cadr(2, 'h10), r); check("R9 ch2 drained", r, 0);
      rd(12'h010, r); check("R5 both flags", r, 32'h5);

      // R3 channel 1 still untouched
      check("R3 ch1 never ran", 32'(ch1_starts), 0);
      rd(cadr(1, 'h10), r); check("R3 ch1 count", r, 32'd255);

      summary();
      $finish;
   end
endmodule